// File: doc/BRIEF.md
# Numerically Controlled Carrier Generator with Complex-to-Real Mixer

This block turns a complex baseband stream that has already been interpolated up to the processing clock rate into one real passband sample per clock. A phase register advances by a programmable tuning word on every clock edge. The upper bits of the phase select a sine and a cosine value from a quarter-wave table that is computed at elaboration. The bits just below them linearly correct between neighbouring table points. The mixer multiplies the I and Q samples by the two carriers, subtracts the products, then rounds and saturates the result to the output width.

The carrier frequency is `tune_word / 2^PHASE_W` times the clock rate. The resolution is therefore one part in 2^32 of the clock at the default width. The tuning word can change on any clock and is used without a restart, so the carrier phase stays continuous across a frequency hop. The I/Q inputs carry a new sample every clock. There is no valid strobe, and the output never stalls.

Top module: `dds_upmix`

## Requirements
- R1: A PHASE_W-bit phase register (32 bits by default) adds `tune_word` on every rising edge and wraps modulo 2^PHASE_W. A zero tuning word holds the phase.
- R2: A new `tune_word` value is used from the next rising edge. The phase accumulated so far is kept and is not reset.
- R3: `y_out` equals round(I·cos θ − Q·sin θ) within ±2 LSB, where θ = 2π·phase/2^PHASE_W. The phase used is the one the register holds while that I/Q pair is applied, and the result appears after the second rising edge that follows.
- R4: When the phase is exactly 0, `y_out` equals I exactly.
- R5: When the phase is exactly 2^(PHASE_W−2) (a quarter turn), `y_out` equals −Q exactly. For Q = −2^(DATA_W−1) the result saturates to 2^(OUT_W−1)−1.
- R6: Results outside the output range are clamped to 2^(OUT_W−1)−1 or to −2^(OUT_W−1) rather than wrapping.
- R7: While `rst` is high, `y_out` is 0. After `rst` falls, the phase restarts from 0.
- R8: The top two phase bits select the quadrant (0: 0–90°, 1: 90–180°, 2: 180–270°, 3: 270–360°). Sine and cosine are built by mirroring and negating the quarter-wave table, so in every quadrant sin²+cos² stays within a narrow band around full scale squared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock; one output sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tune_word | input | PHASE_W | Phase increment added every clock |
| i_in | input | DATA_W | In-phase baseband sample, signed |
| q_in | input | DATA_W | Quadrature baseband sample, signed |
| y_out | output | OUT_W | Real mixed output sample, signed |

## Verification
The bench builds the block with a 32-bit phase, 16-bit I/Q and output, 18-bit carrier amplitude, a 256-entry quarter table and 12 correction bits. With output width equal to input width, the exact identities at phase zero and at a quarter turn reach the rounding boundary, and full-scale inputs at 45° go past both saturation limits. A tuning word that crosses 2^32 within a few clocks exercises wrap-around, and a long sweep passes through all four quadrants.

// File: rtl/dds_upmix_pkg.sv
package dds_upmix_pkg;

   localparam real HALF_PI = 1.5707963267948966;

   // Rounded sine of k/n of a quarter turn, scaled to a signed amp_w-bit full scale.
   function automatic int quarter_sine_code(input int k, input int n, input int amp_w);
      real x;
      real term;
      real acc;
      real scale;
      x     = HALF_PI * real'(k) / real'(n);
      term  = x;
      acc   = x;
      for (int j = 1; j < 14; j++) begin
         term = -term * x * x / real'((2 * j) * (2 * j + 1));
         acc  = acc + term;
      end
      scale = real'((longint'(1) << (amp_w - 1)) - 1);
      return $rtoi(acc * scale + 0.5);
   endfunction

endpackage

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
   parameter int PHASE_W  = 32,
   parameter int OUT_BITS = 22
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [PHASE_W-1:0]  tune,
   output logic [OUT_BITS-1:0] phase_msb
);

   logic [PHASE_W-1:0] acc;

   always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else     acc <= acc + tune;
   end

   assign phase_msb = acc[PHASE_W-1 -: OUT_BITS];

   // R1: a zero increment leaves the phase where it was
   assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
      (tune == '0) |=> $stable(acc));

endmodule

// File: rtl/dds_quarter_interp.sv
module dds_quarter_interp
   import dds_upmix_pkg::*;
#(
   parameter int LUT_AW = 8,
   parameter int FRAC_W = 12,
   parameter int AMP_W  = 18
) (
   input  logic [LUT_AW-1:0]       addr,
   input  logic [FRAC_W-1:0]       frac,
   input  logic                    mirror,
   input  logic                    negate,
   output logic signed [AMP_W-1:0] value
);

   localparam int N  = 1 << LUT_AW;
   localparam int IW = LUT_AW + 1;
   localparam int PW = AMP_W + FRAC_W + 2;
   localparam int MW = AMP_W + 2;

   logic signed [AMP_W-1:0] tbl [0:N];

   for (genvar k = 0; k <= N; k++) begin : g_tbl
      localparam int CODE = quarter_sine_code(k, N, AMP_W);
      assign tbl[k] = AMP_W'(CODE);
   end

   logic [IW-1:0]           idx_lo;
   logic [IW-1:0]           idx_hi;
   logic signed [AMP_W-1:0] lo_v;
   logic signed [AMP_W-1:0] hi_v;
   logic signed [AMP_W:0]   slope;
   logic signed [PW-1:0]    prod;
   logic signed [MW-1:0]    mag;

   always_comb begin
      if (mirror) begin
         idx_lo = IW'(N) - {1'b0, addr};
         idx_hi = idx_lo - IW'(1);
      end else begin
         idx_lo = {1'b0, addr};
         idx_hi = idx_lo + IW'(1);
      end
      lo_v  = tbl[idx_lo];
      hi_v  = tbl[idx_hi];
      slope = (AMP_W+1)'(hi_v) - (AMP_W+1)'(lo_v);
      prod  = PW'(slope) * PW'($signed({1'b0, frac}));
      mag   = MW'(lo_v) + MW'(prod >>> FRAC_W);
      value = negate ? AMP_W'(-mag) : AMP_W'(mag);
   end

endmodule

// File: rtl/dds_sincos.sv
module dds_sincos
   import dds_upmix_pkg::*;
#(
   parameter int LUT_AW = 8,
   parameter int FRAC_W = 12,
   parameter int AMP_W  = 18
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [LUT_AW+FRAC_W+1:0]   phase_msb,
   output logic signed [AMP_W-1:0]    sin_v,
   output logic signed [AMP_W-1:0]    cos_v
);

   localparam int    TW    = LUT_AW + FRAC_W + 2;
   localparam int    SCALE = (1 << (AMP_W - 1)) - 1;
   localparam real   STEP  = HALF_PI / real'(1 << LUT_AW);
   localparam int    DTOL  = $rtoi(real'(SCALE) * STEP * STEP / 8.0) + 4;
   localparam longint RLO  = longint'(SCALE) * SCALE - 2 * longint'(DTOL) * SCALE;
   localparam longint RHI  = longint'(SCALE) * SCALE + 2 * longint'(DTOL) * SCALE
                             + longint'(DTOL) * DTOL;
   localparam int    R2W   = 2 * AMP_W + 2;

   logic [1:0]        quad;
   logic [LUT_AW-1:0] addr;
   logic [FRAC_W-1:0] frac;

   assign quad = phase_msb[TW-1 -: 2];
   assign addr = phase_msb[TW-3 -: LUT_AW];
   assign frac = phase_msb[FRAC_W-1:0];

   logic signed [AMP_W-1:0] wave [2];

   // channel 0 is sine, channel 1 is cosine (sine advanced by one quadrant)
   for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      logic [1:0] qe;
      assign qe = quad + 2'(ch);
      dds_quarter_interp #(
         .LUT_AW(LUT_AW),
         .FRAC_W(FRAC_W),
         .AMP_W (AMP_W)
      ) u_quarter (
         .addr  (addr),
         .frac  (frac),
         .mirror(qe[0]),
         .negate(qe[1]),
         .value (wave[ch])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sin_v <= '0;
         cos_v <= AMP_W'(SCALE);
      end else begin
         sin_v <= wave[0];
         cos_v <= wave[1];
      end
   end

   logic signed [R2W-1:0] rad2;
   always_comb rad2 = R2W'(sin_v) * R2W'(sin_v) + R2W'(cos_v) * R2W'(cos_v);

   // R8: both table paths stay on the full-scale circle in every quadrant
   assert_unit_circle_R8: assert property (@(posedge clk) disable iff (rst)
      (rad2 >= R2W'(RLO)) && (rad2 <= R2W'(RHI)));

endmodule

// File: rtl/dds_iq_mixer.sv
module dds_iq_mixer #(
   parameter int DATA_W   = 16,
   parameter int AMP_W    = 18,
   parameter int OUT_W    = 16,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [DATA_W-1:0] i_in,
   input  logic signed [DATA_W-1:0] q_in,
   input  logic signed [AMP_W-1:0]  sin_v,
   input  logic signed [AMP_W-1:0]  cos_v,
   output logic signed [OUT_W-1:0]  y
);

   localparam int AW    = DATA_W + AMP_W + 2;
   localparam int SCALE = (1 << (AMP_W - 1)) - 1;
   localparam logic signed [AW-1:0] OMAX = AW'((longint'(1) << (OUT_W - 1)) - 1);
   localparam logic signed [AW-1:0] OMIN = AW'(-(longint'(1) << (OUT_W - 1)));
   localparam logic signed [AW-1:0] HALF = AW'(longint'(1) << (AMP_W - 2));

   logic signed [DATA_W-1:0] i_d;
   logic signed [DATA_W-1:0] q_d;
   logic signed [AW-1:0]     acc;
   logic signed [AW-1:0]     rnd;
   logic signed [AW-1:0]     shifted;
   logic signed [OUT_W-1:0]  y_n;

   always_ff @(posedge clk) begin
      if (rst) begin
         i_d <= '0;
         q_d <= '0;
      end else begin
         i_d <= i_in;
         q_d <= q_in;
      end
   end

   always_comb acc = AW'(i_d) * AW'(cos_v) - AW'(q_d) * AW'(sin_v);

   if (ROUND_EN) begin : g_round
      always_comb rnd = acc + HALF;
   end else begin : g_trunc
      always_comb rnd = acc;
   end

   always_comb begin
      shifted = rnd >>> (AMP_W - 1);
      if (shifted > OMAX)      y_n = OUT_W'(OMAX);
      else if (shifted < OMIN) y_n = OUT_W'(OMIN);
      else                     y_n = OUT_W'(shifted);
   end

   always_ff @(posedge clk) begin
      if (rst) y <= '0;
      else     y <= y_n;
   end

   if (OUT_W == DATA_W && ROUND_EN) begin : g_exact_chk
      localparam logic signed [DATA_W-1:0] DMIN = {1'b1, {(DATA_W-1){1'b0}}};
      localparam logic signed [DATA_W-1:0] DMAX = {1'b0, {(DATA_W-1){1'b1}}};

      // R4: carrier at zero phase passes I through unchanged
      assert_zero_phase_R4: assert property (@(posedge clk) disable iff (rst)
         (cos_v == AMP_W'(SCALE) && sin_v == '0) |=> (y == $past(i_d)));

      // R5: carrier at a quarter turn gives the saturated negation of Q
      assert_quarter_phase_R5: assert property (@(posedge clk) disable iff (rst)
         (sin_v == AMP_W'(SCALE) && cos_v == '0) |=>
         (y == (($past(q_d) == DMIN) ? DMAX : -$past(q_d))));
   end

endmodule

// File: rtl/dds_upmix.sv
module dds_upmix #(
   parameter int PHASE_W  = 32,
   parameter int LUT_AW   = 8,
   parameter int FRAC_W   = 12,
   parameter int AMP_W    = 18,
   parameter int DATA_W   = 16,
   parameter int OUT_W    = 16,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [PHASE_W-1:0]       tune_word,
   input  logic signed [DATA_W-1:0] i_in,
   input  logic signed [DATA_W-1:0] q_in,
   output logic signed [OUT_W-1:0]  y_out
);

   localparam int TW = LUT_AW + FRAC_W + 2;

   if (TW > PHASE_W) begin : g_bad_split
      $error("quadrant, table and correction bits exceed the phase width");
   end
   if (AMP_W < 4 || AMP_W > 30) begin : g_bad_amp
      $error("carrier amplitude width out of range");
   end
   if (LUT_AW < 2 || LUT_AW > 11) begin : g_bad_lut
      $error("quarter table address width out of range");
   end
   if (DATA_W + AMP_W + 2 > 62) begin : g_bad_data
      $error("mixer accumulator too wide");
   end
   if (OUT_W < 2 || OUT_W > DATA_W + 2) begin : g_bad_out
      $error("output width out of range");
   end

   logic [TW-1:0]           phase_msb;
   logic signed [AMP_W-1:0] sin_v;
   logic signed [AMP_W-1:0] cos_v;

   dds_phase_accum #(
      .PHASE_W (PHASE_W),
      .OUT_BITS(TW)
   ) u_phase (
      .clk      (clk),
      .rst      (rst),
      .tune     (tune_word),
      .phase_msb(phase_msb)
   );

   dds_sincos #(
      .LUT_AW(LUT_AW),
      .FRAC_W(FRAC_W),
      .AMP_W (AMP_W)
   ) u_sincos (
      .clk      (clk),
      .rst      (rst),
      .phase_msb(phase_msb),
      .sin_v    (sin_v),
      .cos_v    (cos_v)
   );

   dds_iq_mixer #(
      .DATA_W  (DATA_W),
      .AMP_W   (AMP_W),
      .OUT_W   (OUT_W),
      .ROUND_EN(ROUND_EN)
   ) u_mixer (
      .clk  (clk),
      .rst  (rst),
      .i_in (i_in),
      .q_in (q_in),
      .sin_v(sin_v),
      .cos_v(cos_v),
      .y    (y_out)
   );

endmodule

// File: tb/dds_upmix_test.sv
module dds_upmix_test;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [31:0]        tune = '0;
   logic signed [15:0] i_in = '0;
   logic signed [15:0] q_in = '0;
   logic signed [15:0] y;

   int          n_chk  = 0;
   int          n_fail = 0;
   bit          done   = 1'b0;
   logic [31:0] mph    = '0;
   int          p_exp  = 0;
   int          p_tol  = -1;
   string       p_tag  = "";

   always #4 clk = ~clk;

   dds_upmix #(
      .PHASE_W(32), .LUT_AW(8), .FRAC_W(12), .AMP_W(18),
      .DATA_W(16), .OUT_W(16), .ROUND_EN(1'b1)
   ) uut (
      .clk(clk), .rst(rst), .tune_word(tune),
      .i_in(i_in), .q_in(q_in), .y_out(y)
   );

   function automatic int model(input logic [31:0] ph, input int iv, input int qv);
      real th;
      real v;
      th = 6.283185307179586 * real'(ph) / 4294967296.0;
      v  = real'(iv) * $cos(th) - real'(qv) * $sin(th);
      v  = $floor(v + 0.5);
      if (v > 32767.0)  v = 32767.0;
      if (v < -32768.0) v = -32768.0;
      return $rtoi(v);
   endfunction

   task automatic check(input int act, input int exp, input int tol, input string tag);
      int d;
      n_chk++;
      d = act - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d (tol %0d)", tag, act, exp, tol);
      end
   endtask

   // one clock: apply inputs, then check the sample queued one clock earlier
   task automatic tick(input logic [31:0] tw, input int iv, input int qv,
                       input int tol, input string tag);
      int nexp;
      tune = tw;
      i_in = 16'(iv);
      q_in = 16'(qv);
      nexp = model(mph, iv, qv);
      mph  = mph + tw;
      @(negedge clk);
      if (p_tol >= 0) check(int'(y), p_exp, p_tol, p_tag);
      p_exp = nexp;
      p_tol = tol;
      p_tag = tag;
   endtask

   task automatic go_phase(input logic [31:0] target);
      tick(target - mph, 0, 0, -1, "");
   endtask

   task automatic apply_reset();
      rst   = 1'b1;
      p_tol = -1;
      tune  = 32'h1234_5678;
      i_in  = 16'sd9000;
      q_in  = -16'sd9000;
      repeat (3) @(negedge clk);
      check(int'(y), 0, 0, "R7 output zero in reset");
      rst = 1'b0;
      mph = '0;
   endtask

   task automatic test_reset();
      apply_reset();
      tick(0, 1234, -777, 0, "R7 phase restarts at zero / R4");
      tick(0, 0, 0, -1, "");
   endtask

   task automatic test_zero_phase();
      go_phase(32'h0000_0000);
      tick(0, 32767, 12000, 0, "R4 I max at phase 0");
      tick(0, -32768, -5, 0, "R4 I min at phase 0");
      tick(0, -1, 32767, 0, "R4 I=-1 at phase 0");
      tick(0, 0, 0, -1, "");
   endtask

   task automatic test_quarter();
      go_phase(32'h4000_0000);
      tick(0, 500, 1000, 0, "R5 quarter turn");
      tick(0, 0, -32768, 0, "R5 Q min saturates");
      tick(0, -300, 32767, 0, "R5 Q max");
      tick(0, 0, 0, -1, "");
   endtask

   task automatic test_saturation();
      go_phase(32'h2000_0000);
      tick(0, 32767, -32767, 0, "R6 positive clamp");
      tick(0, -32768, 32767, 0, "R6 negative clamp");
      tick(0, 20000, -20000, 2, "R6 in range near limit");
      tick(0, 0, 0, -1, "");
   endtask

   task automatic test_wrap();
      go_phase(32'hC000_0000);
      tick(32'h8000_0000, 0, 1000, 0, "R1 phase 3/4 turn");
      tick(32'h8000_0000, 0, 1000, 0, "R1 wrapped to 1/4 turn");
      tick(0, 0, 1000, 0, "R1 wrapped back to 3/4 turn");
      tick(0, 0, 0, -1, "");
   endtask

   task automatic test_quadrants();
      for (int qd = 0; qd < 4; qd++) begin
         go_phase(32'(qd) * 32'h4000_0000 + 32'h1555_5555);
         tick(0, 20000, 7000, 2, "R8 quadrant sample");
      end
      tick(0, 0, 0, -1, "");
   endtask

   task automatic test_sweep();
      go_phase(32'h0000_0000);
      for (int k = 0; k < 100; k++) begin
         tick(32'h0523_4567, (k * 2971) % 60000 - 30000, (k * 1733) % 60000 - 30000,
              2, "R3 sweep");
      end
      tick(0, 0, 0, -1, "");
   endtask

   task automatic test_retune();
      for (int k = 0; k < 20; k++) begin
         tick((k < 10) ? 32'h0100_0000 : 32'h0A00_0001, 15000, -9000, 2,
              "R2 retune keeps phase");
      end
      tick(0, 0, 0, -1, "");
   endtask

   task automatic test_reset_midrun();
      go_phase(32'h7654_3210);
      tick(32'h0333_0000, 100, 100, -1, "");
      apply_reset();
      tick(0, -2500, 400, 0, "R7 phase zero after reset mid-run");
      tick(0, 0, 0, -1, "");
   endtask

   initial begin
      test_reset();
      test_zero_phase();
      test_quarter();
      test_saturation();
      test_wrap();
      test_quadrants();
      test_sweep();
      test_retune();
      test_reset_midrun();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL R3 watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule